// File: doc/BRIEF.md
# Multiplexed Parallel I/O Port

A 32-pin parallel port in which each pin is either a general-purpose I/O or a dedicated pin for on-chip peripherals. Four configuration registers sit on a simple byte-enabled register bus: a mode register (0 = general-purpose, 1 = dedicated), an option register, a direction register and a data register. In general-purpose mode the direction bit makes the pin an output or an input. Writes to the data register always land in an output latch. Reads of the data register return the synchronized pin level.

In dedicated mode the direction bit chooses between a dedicated output function and a dedicated input function, and the option bit chooses which of two such functions is used. Peripheral signal k appears as the first-option function of pin k and as the second-option function of pin (k - OFS) mod N. One peripheral output can therefore leave the chip on two pins at once. A peripheral input takes its primary pin when that pin is configured for it. Only when the primary is not selected can the secondary pin supply it. When neither pin supplies it, the input gets a fixed per-signal default.

Top module: `pio_port`

## Requirements
- R1: After reset all four registers read 0, every pad output enable is 0, and every peripheral input carries its default value.
- R2: A pin with mode bit 0 drives its pad (`pad_oe_o`=1, `pad_o` = latch bit) when its direction bit is 1. It does not drive (`pad_oe_o`=0) when its direction bit is 0.
- R3: A write to the data register (address 3) updates the output latch whatever the pin direction. A value written while a pin is an input appears on the pad once the pin becomes a general-purpose output.
- R4: A read at address 3 returns the pin levels after a two-flop synchronizer, never the latch contents. The read data is valid one cycle after the read strobe.
- R5: Writes honour the byte enables: byte b of a register changes only when `reg_be_i[b]` is 1.
- R6: The mode (address 0), option (address 1) and direction (address 2) registers read back exactly as written, including option bits with no effect.
- R7: A pin with mode 1 and direction 1 drives its pad. The value is `periph_out_i[p]` when its option bit is 0 and `periph_out_i[(p+OFS)%N]` when its option bit is 1 (OFS = 16 by default).
- R8: A pin with mode 1 and direction 0 never drives its pad. Peripheral input k follows synchronized pad k, two clock edges after the pad changes, when pin k has mode 1, direction 0 and option 0 (primary).
- R9: When pin k is not primary for input k, input k follows synchronized pad s = (k+N-OFS)%N if pin s has mode 1, direction 0 and option 1 (secondary). A configured secondary is ignored when the primary is configured.
- R10: A peripheral input with neither its primary nor its secondary pin configured receives bit k of the IN_DEFAULT parameter.
- R11: The same peripheral output may appear on two pins at once when both are configured for it.
- R12: With mode bit 0 the option bit and the peripheral outputs have no effect on the pad, and that pin supplies no peripheral input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register index: 0 mode, 1 option, 2 direction, 3 data |
| reg_be_i | input | 4 | Byte enables for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output values (0 where not driven) |
| pad_oe_o | output | 32 | Pad output enables |
| periph_out_i | input | 32 | Peripheral output functions, one per signal index |
| periph_in_o | output | 32 | Peripheral input functions, one per signal index |

## Verification
Pad outputs and enables depend only on register state, so they are due in the cycle after the write edge. The bench drives inputs at a falling edge and samples them at the next falling edge. Pad levels reach `periph_in_o` two rising edges after they change. The bench checks one edge after a change that the old value still holds, and checks the new value after the second edge. Read data needs one more edge after the strobe, so every read samples `reg_rdata_o` at the falling edge that follows the capturing rising edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_ALT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_DATA = 2'd3
  } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  localparam int unsigned N_BYTES = N_PINS / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [1:0]         addr_i,
  input  logic [N_BYTES-1:0] be_i,
  input  logic [N_PINS-1:0]  wdata_i,
  input  logic [N_PINS-1:0]  pin_sync_i,
  output logic [N_PINS-1:0]  mode_o,
  output logic [N_PINS-1:0]  alt_o,
  output logic [N_PINS-1:0]  dir_o,
  output logic [N_PINS-1:0]  latch_o,
  output logic [N_PINS-1:0]  rdata_o
);
  pio_reg_e     sel;
  logic [N_PINS-1:0] rd_mux;

  assign sel = pio_reg_e'(addr_i);

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_o[8*b +: 8]  <= '0;
        alt_o[8*b +: 8]   <= '0;
        dir_o[8*b +: 8]   <= '0;
        latch_o[8*b +: 8] <= '0;
      end else if (wr_i && be_i[b]) begin
        unique case (sel)
          REG_MODE: mode_o[8*b +: 8]  <= wdata_i[8*b +: 8];
          REG_ALT:  alt_o[8*b +: 8]   <= wdata_i[8*b +: 8];
          REG_DIR:  dir_o[8*b +: 8]   <= wdata_i[8*b +: 8];
          REG_DATA: latch_o[8*b +: 8] <= wdata_i[8*b +: 8];
        endcase
      end
    end
  end

  // data reads return the pin, never the latch
  always_comb begin
    unique case (sel)
      REG_MODE: rd_mux = mode_o;
      REG_ALT:  rd_mux = alt_o;
      REG_DIR:  rd_mux = dir_o;
      REG_DATA: rd_mux = pin_sync_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/pio_out_mux.sv
module pio_out_mux #(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned OFS    = 16
) (
  input  logic [N_PINS-1:0] mode_i,
  input  logic [N_PINS-1:0] alt_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] latch_i,
  input  logic [N_PINS-1:0] periph_out_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam int unsigned ALT_SIG = (p + OFS) % N_PINS;
    logic ded_val;

    assign ded_val     = alt_i[p] ? periph_out_i[ALT_SIG] : periph_out_i[p];
    assign pad_oe_o[p] = dir_i[p];
    assign pad_o[p]    = !dir_i[p] ? 1'b0 : (mode_i[p] ? ded_val : latch_i[p]);
  end
endmodule

// File: rtl/pio_in_route.sv
module pio_in_route #(
  parameter int unsigned        N_PINS     = 32,
  parameter int unsigned        OFS        = 16,
  parameter logic [N_PINS-1:0]  IN_DEFAULT = '0
) (
  input  logic [N_PINS-1:0] mode_i,
  input  logic [N_PINS-1:0] alt_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] pin_sync_i,
  output logic [N_PINS-1:0] periph_in_o
);
  logic [N_PINS-1:0] ded_in;

  assign ded_in = mode_i & ~dir_i;

  for (genvar k = 0; k < N_PINS; k++) begin : g_sig
    localparam int unsigned SEC_PIN = (k + N_PINS - OFS) % N_PINS;
    logic prim_sel, sec_sel;

    assign prim_sel = ded_in[k] && !alt_i[k];
    assign sec_sel  = ded_in[SEC_PIN] && alt_i[SEC_PIN];
    // primary wins; secondary only counts while primary is unselected
    assign periph_in_o[k] = prim_sel ? pin_sync_i[k] :
                            sec_sel  ? pin_sync_i[SEC_PIN] : IN_DEFAULT[k];
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int unsigned       N_PINS     = 32,
  parameter int unsigned       OFS        = 16,
  parameter logic [N_PINS-1:0] IN_DEFAULT = 32'h0F0F_3C3C,
  localparam int unsigned      N_BYTES    = N_PINS / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [N_BYTES-1:0] reg_be_i,
  input  logic [N_PINS-1:0]  reg_wdata_i,
  output logic [N_PINS-1:0]  reg_rdata_o,
  input  logic [N_PINS-1:0]  pad_i,
  output logic [N_PINS-1:0]  pad_o,
  output logic [N_PINS-1:0]  pad_oe_o,
  input  logic [N_PINS-1:0]  periph_out_i,
  output logic [N_PINS-1:0]  periph_in_o
);
  logic [N_PINS-1:0] cfg_mode, cfg_alt, cfg_dir, out_latch, pin_sync;

  pio_sync #(.W(N_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pin_sync)
  );

  pio_regs #(.N_PINS(N_PINS)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .be_i       (reg_be_i),
    .wdata_i    (reg_wdata_i),
    .pin_sync_i (pin_sync),
    .mode_o     (cfg_mode),
    .alt_o      (cfg_alt),
    .dir_o      (cfg_dir),
    .latch_o    (out_latch),
    .rdata_o    (reg_rdata_o)
  );

  pio_out_mux #(.N_PINS(N_PINS), .OFS(OFS)) i_out_mux (
    .mode_i       (cfg_mode),
    .alt_i        (cfg_alt),
    .dir_i        (cfg_dir),
    .latch_i      (out_latch),
    .periph_out_i (periph_out_i),
    .pad_o        (pad_o),
    .pad_oe_o     (pad_oe_o)
  );

  pio_in_route #(.N_PINS(N_PINS), .OFS(OFS), .IN_DEFAULT(IN_DEFAULT)) i_in_route (
    .mode_i      (cfg_mode),
    .alt_i       (cfg_alt),
    .dir_i       (cfg_dir),
    .pin_sync_i  (pin_sync),
    .periph_in_o (periph_in_o)
  );
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int unsigned  N_PINS  = 32,
  localparam int unsigned N_BYTES = N_PINS / 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [1:0]         reg_addr_i,
  input logic [N_BYTES-1:0] reg_be_i,
  input logic [N_PINS-1:0]  reg_wdata_i,
  input logic [N_PINS-1:0]  reg_rdata_o,
  input logic [N_PINS-1:0]  pad_i,
  input logic [N_PINS-1:0]  pad_o,
  input logic [N_PINS-1:0]  pad_oe_o,
  input logic [N_PINS-1:0]  mode_i,
  input logic [N_PINS-1:0]  dir_i
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (pad_oe_o == '0 && reg_rdata_o == '0);
    end
  end

  a_r2_gpio_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mode_i & ~dir_i & pad_oe_o) == '0) && ((~mode_i & dir_i & ~pad_oe_o) == '0));

  a_r3_latch_to_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd3 && reg_be_i == '1)
    |=> (((pad_o ^ $past(reg_wdata_i)) & ~mode_i & dir_i) == '0));

  a_r4_read_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd3 && age_q == 2'd3)
    |=> (reg_rdata_o == $past(pad_i, 3)));

  a_r5_byte_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && !reg_be_i[0]) |=> $stable(mode_i[7:0]));

  a_r7_ded_out_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i & dir_i & ~pad_oe_o) == '0);

  a_r8_ded_in_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i & ~dir_i & pad_oe_o) == '0);
endmodule

bind pio_port pio_port_chk #(.N_PINS(N_PINS)) i_pio_port_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_be_i    (reg_be_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .mode_i      (cfg_mode),
  .dir_i       (cfg_dir)
);

// File: tb/test_pio_port.sv
module test_pio_port;
  localparam int unsigned N   = 32;
  localparam int unsigned OFS = 16;
  localparam logic [N-1:0] DEF = 32'h0F0F_3C3C;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [3:0] reg_be_i = '0;
  logic [N-1:0] reg_wdata_i = '0, pad_i = '0, periph_out_i = '0;
  logic [N-1:0] reg_rdata_o, pad_o, pad_oe_o, periph_in_o;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_mode = '0, m_alt = '0, m_dir = '0;

  always #10 clk_i = ~clk_i;

  pio_port i_pio_port (.*);

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_be_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic cfg(input logic [N-1:0] mo, input logic [N-1:0] al, input logic [N-1:0] di);
    m_mode = mo; m_alt = al; m_dir = di;
    wr(2'd0, mo); wr(2'd1, al); wr(2'd2, di);
  endtask

  task automatic set_pad(input logic [N-1:0] v);
    @(negedge clk_i);
    pad_i = v;
    repeat (2) @(negedge clk_i);
  endtask

  function automatic logic [N-1:0] rot(input logic [N-1:0] x);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = x[(p + OFS) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_in(input logic [N-1:0] pad);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      int s;
      s = (k + N - OFS) % N;
      if (m_mode[k] && !m_dir[k] && !m_alt[k])      r[k] = pad[k];
      else if (m_mode[s] && !m_dir[s] && m_alt[s])  r[k] = pad[s];
      else                                          r[k] = DEF[k];
    end
    return r;
  endfunction

  task automatic t_reset;
    logic [N-1:0] v;
    check("R1 oe", pad_oe_o, '0);
    check("R1 periph_in default", periph_in_o, DEF);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], v);
      check("R1 reg", v, '0);
    end
  endtask

  task automatic t_gpio;
    wr(2'd3, 32'h1234_5678);
    cfg('0, '0, 32'hFFFF_0000);
    check("R2 oe", pad_oe_o, 32'hFFFF_0000);
    check("R2 pad_o", pad_o & pad_oe_o, 32'h1234_0000);
    cfg('0, '0, '0);
    wr(2'd3, 32'hCAFE_F00D);
    check("R2 input no drive", pad_oe_o, '0);
    cfg('0, '0, '1);
    check("R3 latched while input", pad_o, 32'hCAFE_F00D);
  endtask

  task automatic t_read;
    logic [N-1:0] v;
    set_pad(32'h5A5A_C3C3);
    rd(2'd3, v);
    check("R4 read pin as output", v, 32'h5A5A_C3C3);
    cfg('0, '0, '0);
    set_pad(32'h0F1E_2D3C);
    rd(2'd3, v);
    check("R4 read pin as input", v, 32'h0F1E_2D3C);
  endtask

  task automatic t_bytes;
    logic [N-1:0] v;
    cfg('0, '0, '0);
    wr(2'd0, 32'hFFFF_FFFF, 4'b0100);
    rd(2'd0, v);
    check("R5 byte enable", v, 32'h00FF_0000);
    wr(2'd0, 32'h0000_0000, 4'b0100);
    wr(2'd1, 32'hDEAD_BEEF);
    rd(2'd1, v);
    check("R6 option readback", v, 32'hDEAD_BEEF);
    wr(2'd2, 32'h8421_0F0F);
    rd(2'd2, v);
    check("R6 direction readback", v, 32'h8421_0F0F);
    wr(2'd2, '0);
  endtask

  task automatic t_ded_out;
    @(negedge clk_i) periph_out_i = 32'h9ABC_1357;
    cfg('1, '0, '1);
    check("R7 oe", pad_oe_o, '1);
    check("R7 option0", pad_o, 32'h9ABC_1357);
    cfg('1, '1, '1);
    check("R7 option1", pad_o, rot(32'h9ABC_1357));
    cfg('1, 32'h0000_FFFF, '1);
    check("R11 two pins", pad_o[15:0], pad_o[31:16]);
    check("R11 value", pad_o, {2{16'h9ABC}});
  endtask

  task automatic t_ded_in;
    cfg('1, '0, '0);
    set_pad('0);
    check("R8 no drive", pad_oe_o, '0);
    @(negedge clk_i) pad_i = 32'hA5C3_7E19;
    @(negedge clk_i);
    check("R8 sync one edge", periph_in_o, '0);
    @(negedge clk_i);
    check("R8 primary", periph_in_o, 32'hA5C3_7E19);
    cfg('1, '1, '0);
    check("R9 secondary", periph_in_o, exp_in(32'hA5C3_7E19));
    cfg('1, 32'h0000_FFFF, '0);
    check("R10 default low half", periph_in_o, exp_in(32'hA5C3_7E19));
    cfg('1, 32'hFFFF_0000, '0);
    check("R9 primary wins", periph_in_o, exp_in(32'hA5C3_7E19));
  endtask

  task automatic t_gpio_ignore;
    cfg('0, '1, '1);
    wr(2'd3, 32'h7777_0001);
    @(negedge clk_i) periph_out_i = 32'hFFFF_FFFF;
    set_pad(32'h1111_2222);
    check("R12 pad ignores periph", pad_o, 32'h7777_0001);
    check("R12 no periph input", periph_in_o, DEF);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #5 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gpio();
    t_read();
    t_bytes();
    t_ded_out();
    t_ded_in();
    t_gpio_ignore();
    finish_run();
  end
endmodule